// File: doc/BRIEF.md
# Non-temporal load-pair decoder and address generator

This block takes one 32-bit instruction word for a load of two registers with a non-temporal hint. It checks the fixed opcode bits and the load bit, and it pulls out the two destination register indices and the base register index. It sorts the word into one of five kinds: no match, a valid pair of 32-bit words, a valid pair of 64-bit words, undefined, or a no-operation. The signed 7-bit offset field is scaled by the access size and added to a base value. The base value comes from a 64-bit register-file read port, or from the stack-pointer input when the base index is 31.

The block also reports three things. It says whether the access is tag-checked. It raises a fault when the stack pointer is the base and is not aligned. When both destination indices are equal, it resolves the outcome with a policy chosen by an input. The register-file read index leaves the block combinationally, so the read data can come back in the same cycle. The decode itself is combinational, and its results are registered once, qualified by a valid strobe. Memory access, register writeback and exception delivery are done elsewhere.

Top module: `lpair_dec`

## Requirements
- R1: `match_o` is 1 only when insn bits [29:23] equal 7'b1010000 and bit 22 (load) is 1. When it is 0, every other decode output is 0, except `valid_o`.
- R2: `kind_o` is encoded as 0 = no match, 1 = 32-bit pair (opc bits [31:30] = 00), 2 = 64-bit pair (opc = 10), 3 = undefined, 4 = no-operation. When opc bit 30 is 1, the kind is undefined, whatever the overlap policy says.
- R3: On a match, `rt_o` = insn[4:0], `rn_o` = insn[9:5] and `rt2_o` = insn[14:10], for every kind.
- R4: For pair kinds, `addr_o` = base + (sign-extended insn[21:15] shifted left by 2 for a 32-bit pair, or by 3 for a 64-bit pair), taken modulo 2^64.
- R5: `rf_raddr_o` equals insn[9:5] in the same cycle. For pair kinds, an index of 31 selects `sp_i` as the base and sets `sp_base_o` = 1 and `tag_chk_o` = 0. Any other index selects `base_rdata_i` and sets `tag_chk_o` = 1 and `sp_base_o` = 0.
- R6: `sp_align_fault_o` = 1 exactly when the kind is a pair, the stack pointer is the base, `align_chk_en_i` = 1 and `sp_i[3:0]` is not zero.
- R7: When opc = 00 or 10 and Rt equals Rt2, `ovl_policy_i` decides the outcome. 2'b00 keeps the pair kind and sets `rt_unknown_o`. 2'b01 and 2'b11 give undefined. 2'b10 gives no-operation. `rt_unknown_o` is 0 in every other case.
- R8: For the undefined and no-operation kinds, `addr_o`, `sp_base_o`, `tag_chk_o`, `sp_align_fault_o` and `rt_unknown_o` are all 0.
- R9: All outputs except `rf_raddr_o` update at the clock edge that samples `valid_i` = 1, and `valid_o` follows `valid_i` one cycle later. While `valid_i` = 0, the data outputs keep their values.
- R10: While `rst_ni` is low, all registered outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word and base data are valid |
| insn_i | input | 32 | Instruction word |
| base_rdata_i | input | 64 | Register-file read data for `rf_raddr_o` |
| sp_i | input | 64 | Current stack pointer |
| align_chk_en_i | input | 1 | Enables the stack-pointer alignment check |
| ovl_policy_i | input | 2 | Outcome policy for equal destination indices |
| rf_raddr_o | output | 5 | Combinational base register read index |
| valid_o | output | 1 | Registered outputs are valid |
| match_o | output | 1 | Word is a load pair with a non-temporal hint |
| kind_o | output | 3 | Decode kind |
| rt_o | output | 5 | First destination index |
| rt2_o | output | 5 | Second destination index |
| rn_o | output | 5 | Base register index |
| addr_o | output | 64 | Effective byte address |
| sp_base_o | output | 1 | Stack pointer used as base |
| tag_chk_o | output | 1 | Access is tag-checked |
| sp_align_fault_o | output | 1 | Stack-pointer alignment fault |
| rt_unknown_o | output | 1 | Loaded results are UNKNOWN |

## Verification
The offset field is driven with +1, the most positive value, the most negative value and -1, for both access sizes. This separates a shift by 2 from a shift by 3, and proper sign extension from zero extension. A base near the top of the address space checks that the sum wraps. The base is switched between a general index and index 31, with an aligned stack pointer, a misaligned one, and the check disabled, to confirm the base selection and to confirm that the fault is gated only by its own conditions. Equal destination indices are tried under all four policy codes and together with an undefined opc. Words with a flipped fixed bit or a cleared load bit show that non-matching words are suppressed.

// File: rtl/lpd_pkg.sv
package lpd_pkg;
  localparam int unsigned REG_IDX_W = 5;
  localparam int unsigned IMM_W     = 7;
  localparam logic [REG_IDX_W-1:0] SP_IDX = 5'd31;
  localparam logic [6:0] FIXED_BITS = 7'b1010000;

  typedef enum logic [2:0] {
    KIND_NONE  = 3'd0,
    KIND_P32   = 3'd1,
    KIND_P64   = 3'd2,
    KIND_UNDEF = 3'd3,
    KIND_NOP   = 3'd4
  } kind_e;

  typedef enum logic [1:0] {
    POL_UNKNOWN = 2'b00,
    POL_UNDEF   = 2'b01,
    POL_NOP     = 2'b10,
    POL_RSVD    = 2'b11
  } ovl_pol_e;

  typedef struct packed {
    logic                 match;
    kind_e                kind;
    logic [REG_IDX_W-1:0] rt;
    logic [REG_IDX_W-1:0] rt2;
    logic [REG_IDX_W-1:0] rn;
    logic [IMM_W-1:0]     imm;
    logic                 wide;
    logic                 rt_unknown;
  } dec_t;
endpackage

// File: rtl/lpd_field_decode.sv
module lpd_field_decode
  import lpd_pkg::*;
(
  input  logic [31:0] insn_i,
  input  logic [1:0]  ovl_policy_i,
  output dec_t        dec_o
);
  logic [1:0] opc;
  logic       fixed_ok, is_load, overlap;
  kind_e      pair_kind;

  assign opc       = insn_i[31:30];
  assign fixed_ok  = (insn_i[29:23] == FIXED_BITS);
  assign is_load   = insn_i[22];
  assign overlap   = (insn_i[4:0] == insn_i[14:10]);
  assign pair_kind = opc[1] ? KIND_P64 : KIND_P32;

  always_comb begin
    dec_o = '0;
    if (fixed_ok && is_load) begin
      dec_o.match = 1'b1;
      dec_o.rt    = insn_i[4:0];
      dec_o.rn    = insn_i[9:5];
      dec_o.rt2   = insn_i[14:10];
      dec_o.imm   = insn_i[21:15];
      dec_o.wide  = opc[1];
      if (opc[0]) begin
        dec_o.kind = KIND_UNDEF;
      end else if (overlap) begin
        unique case (ovl_pol_e'(ovl_policy_i))
          POL_UNKNOWN: begin
            dec_o.kind       = pair_kind;
            dec_o.rt_unknown = 1'b1;
          end
          POL_NOP: dec_o.kind = KIND_NOP;
          default: dec_o.kind = KIND_UNDEF;
        endcase
      end else begin
        dec_o.kind = pair_kind;
      end
    end
  end
endmodule

// File: rtl/lpd_addr_gen.sv
module lpd_addr_gen
  import lpd_pkg::*;
#(
  parameter int unsigned XLEN       = 64,
  parameter int unsigned ALIGN_BITS = 4
) (
  input  logic                 pair_i,
  input  logic                 wide_i,
  input  logic [IMM_W-1:0]     imm_i,
  input  logic [REG_IDX_W-1:0] rn_i,
  input  logic [XLEN-1:0]      base_rdata_i,
  input  logic [XLEN-1:0]      sp_i,
  input  logic                 align_chk_en_i,
  output logic [XLEN-1:0]      addr_o,
  output logic                 sp_base_o,
  output logic                 tag_chk_o,
  output logic                 sp_align_fault_o
);
  localparam int unsigned EXT_W = XLEN - IMM_W;

  logic [XLEN-1:0] imm_ext, offset, base;
  logic [1:0]      shamt;
  logic            use_sp, sp_misaligned;

  assign imm_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
  assign shamt   = 2'd2 + {1'b0, wide_i};
  assign offset  = imm_ext << shamt;
  assign use_sp  = (rn_i == SP_IDX);
  assign base    = use_sp ? sp_i : base_rdata_i;

  generate
    if (ALIGN_BITS > 0) begin : g_align
      assign sp_misaligned = |sp_i[ALIGN_BITS-1:0];
    end else begin : g_no_align
      assign sp_misaligned = 1'b0;
    end
  endgenerate

  always_comb begin
    addr_o           = '0;
    sp_base_o        = 1'b0;
    tag_chk_o        = 1'b0;
    sp_align_fault_o = 1'b0;
    if (pair_i) begin
      addr_o           = base + offset;
      sp_base_o        = use_sp;
      tag_chk_o        = !use_sp;
      sp_align_fault_o = use_sp && align_chk_en_i && sp_misaligned;
    end
  end
endmodule

// File: rtl/lpair_dec.sv
module lpair_dec
  import lpd_pkg::*;
#(
  parameter int unsigned XLEN       = 64,
  parameter int unsigned ALIGN_BITS = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [31:0]     insn_i,
  input  logic [XLEN-1:0] base_rdata_i,
  input  logic [XLEN-1:0] sp_i,
  input  logic            align_chk_en_i,
  input  logic [1:0]      ovl_policy_i,
  output logic [4:0]      rf_raddr_o,
  output logic            valid_o,
  output logic            match_o,
  output logic [2:0]      kind_o,
  output logic [4:0]      rt_o,
  output logic [4:0]      rt2_o,
  output logic [4:0]      rn_o,
  output logic [XLEN-1:0] addr_o,
  output logic            sp_base_o,
  output logic            tag_chk_o,
  output logic            sp_align_fault_o,
  output logic            rt_unknown_o
);
  dec_t            dec;
  logic            is_pair;
  logic [XLEN-1:0] addr_d;
  logic            sp_base_d, tag_chk_d, fault_d;

  assign rf_raddr_o = insn_i[9:5];

  lpd_field_decode i_field_decode (
    .insn_i       (insn_i),
    .ovl_policy_i (ovl_policy_i),
    .dec_o        (dec)
  );

  assign is_pair = (dec.kind == KIND_P32) || (dec.kind == KIND_P64);

  lpd_addr_gen #(
    .XLEN       (XLEN),
    .ALIGN_BITS (ALIGN_BITS)
  ) i_addr_gen (
    .pair_i           (is_pair),
    .wide_i           (dec.wide),
    .imm_i            (dec.imm),
    .rn_i             (dec.rn),
    .base_rdata_i     (base_rdata_i),
    .sp_i             (sp_i),
    .align_chk_en_i   (align_chk_en_i),
    .addr_o           (addr_d),
    .sp_base_o        (sp_base_d),
    .tag_chk_o        (tag_chk_d),
    .sp_align_fault_o (fault_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o          <= 1'b0;
      match_o          <= 1'b0;
      kind_o           <= KIND_NONE;
      rt_o             <= '0;
      rt2_o            <= '0;
      rn_o             <= '0;
      addr_o           <= '0;
      sp_base_o        <= 1'b0;
      tag_chk_o        <= 1'b0;
      sp_align_fault_o <= 1'b0;
      rt_unknown_o     <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        match_o          <= dec.match;
        kind_o           <= dec.kind;
        rt_o             <= dec.rt;
        rt2_o            <= dec.rt2;
        rn_o             <= dec.rn;
        addr_o           <= addr_d;
        sp_base_o        <= sp_base_d;
        tag_chk_o        <= tag_chk_d;
        sp_align_fault_o <= fault_d;
        rt_unknown_o     <= dec.rt_unknown;
      end
    end
  end

  a_r1_nomatch_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !match_o |-> (kind_o == KIND_NONE) && (rn_o == '0) && (rt_o == '0) && (addr_o == '0)
                 && !tag_chk_o && !sp_base_o && !rt_unknown_o);

  a_r5_base_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((kind_o == KIND_P32) || (kind_o == KIND_P64)) |-> (tag_chk_o ^ sp_base_o));

  a_r5_sp_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_base_o |-> (rn_o == SP_IDX));

  a_r6_fault_needs_sp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_align_fault_o |-> sp_base_o);

  a_r7_unknown_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rt_unknown_o |-> (rt_o == rt2_o) && ((kind_o == KIND_P32) || (kind_o == KIND_P64)));

  a_r8_inactive_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((kind_o == KIND_UNDEF) || (kind_o == KIND_NOP)) |->
      (addr_o == '0) && !tag_chk_o && !sp_base_o && !sp_align_fault_o && !rt_unknown_o);

  a_r9_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(addr_o) && $stable(kind_o) && $stable(rn_o));
endmodule

// File: tb/test_lpair_dec.sv
`timescale 1ns/1ps
module test_lpair_dec;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic [63:0] base_rdata_i = '0, sp_i = '0;
  logic        align_chk_en_i = 1'b0;
  logic [1:0]  ovl_policy_i = '0;
  logic [4:0]  rf_raddr_o, rt_o, rt2_o, rn_o;
  logic        valid_o, match_o, sp_base_o, tag_chk_o, sp_align_fault_o, rt_unknown_o;
  logic [2:0]  kind_o;
  logic [63:0] addr_o;

  always #4 clk = ~clk;

  lpair_dec i_lpair_dec (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .insn_i(insn_i),
    .base_rdata_i(base_rdata_i), .sp_i(sp_i), .align_chk_en_i(align_chk_en_i),
    .ovl_policy_i(ovl_policy_i), .rf_raddr_o(rf_raddr_o), .valid_o(valid_o),
    .match_o(match_o), .kind_o(kind_o), .rt_o(rt_o), .rt2_o(rt2_o), .rn_o(rn_o),
    .addr_o(addr_o), .sp_base_o(sp_base_o), .tag_chk_o(tag_chk_o),
    .sp_align_fault_o(sp_align_fault_o), .rt_unknown_o(rt_unknown_o)
  );

  typedef struct packed {
    logic [1:0]  opc;
    logic [6:0]  fix;
    logic        ld;
    logic [6:0]  imm;
    logic [4:0]  rt2;
    logic [4:0]  rn;
    logic [4:0]  rt;
    logic [63:0] base;
    logic [63:0] sp;
    logic        en;
    logic [1:0]  pol;
    logic [2:0]  kind;
    logic [63:0] addr;
  } vec_t;

  localparam int NV = 20;
  localparam logic [6:0] FX = 7'b1010000;
  localparam vec_t VEC [NV] = '{
    '{2'b00, FX, 1'b1, 7'h01, 5'd2, 5'd3,  5'd1, 64'h1000, 64'h2000, 1'b1, 2'b00, 3'd1, 64'h1004},
    '{2'b10, FX, 1'b1, 7'h01, 5'd2, 5'd3,  5'd1, 64'h1000, 64'h2000, 1'b1, 2'b00, 3'd2, 64'h1008},
    '{2'b00, FX, 1'b1, 7'h40, 5'd4, 5'd6,  5'd7, 64'h1000, 64'h2000, 1'b1, 2'b00, 3'd1, 64'h0F00},
    '{2'b10, FX, 1'b1, 7'h40, 5'd4, 5'd6,  5'd7, 64'h1000, 64'h2000, 1'b1, 2'b00, 3'd2, 64'h0E00},
    '{2'b00, FX, 1'b1, 7'h3F, 5'd8, 5'd9,  5'd0, 64'h1000, 64'h2000, 1'b1, 2'b00, 3'd1, 64'h10FC},
    '{2'b10, FX, 1'b1, 7'h3F, 5'd8, 5'd9,  5'd0, 64'h1000, 64'h2000, 1'b1, 2'b00, 3'd2, 64'h11F8},
    '{2'b10, FX, 1'b1, 7'h7F, 5'd30,5'd29, 5'd28,64'h1000, 64'h2000, 1'b1, 2'b00, 3'd2, 64'h0FF8},
    '{2'b10, FX, 1'b1, 7'h02, 5'd2, 5'd31, 5'd1, 64'h1000, 64'h2000, 1'b1, 2'b00, 3'd2, 64'h2010},
    '{2'b00, FX, 1'b1, 7'h00, 5'd2, 5'd31, 5'd1, 64'h1000, 64'h2008, 1'b1, 2'b00, 3'd1, 64'h2008},
    '{2'b00, FX, 1'b1, 7'h00, 5'd2, 5'd31, 5'd1, 64'h1000, 64'h2008, 1'b0, 2'b00, 3'd1, 64'h2008},
    '{2'b01, FX, 1'b1, 7'h01, 5'd2, 5'd3,  5'd1, 64'h1000, 64'h2000, 1'b1, 2'b00, 3'd3, 64'h0},
    '{2'b11, FX, 1'b1, 7'h01, 5'd2, 5'd31, 5'd1, 64'h1000, 64'h2008, 1'b1, 2'b00, 3'd3, 64'h0},
    '{2'b10, FX, 1'b1, 7'h01, 5'd5, 5'd3,  5'd5, 64'h1000, 64'h2000, 1'b1, 2'b00, 3'd2, 64'h1008},
    '{2'b10, FX, 1'b1, 7'h01, 5'd5, 5'd3,  5'd5, 64'h1000, 64'h2000, 1'b1, 2'b01, 3'd3, 64'h0},
    '{2'b10, FX, 1'b1, 7'h01, 5'd5, 5'd3,  5'd5, 64'h1000, 64'h2000, 1'b1, 2'b10, 3'd4, 64'h0},
    '{2'b10, FX, 1'b1, 7'h01, 5'd5, 5'd3,  5'd5, 64'h1000, 64'h2000, 1'b1, 2'b11, 3'd3, 64'h0},
    '{2'b01, FX, 1'b1, 7'h01, 5'd5, 5'd3,  5'd5, 64'h1000, 64'h2000, 1'b1, 2'b10, 3'd3, 64'h0},
    '{2'b10, 7'b1010001, 1'b1, 7'h01, 5'd2, 5'd3, 5'd1, 64'h1000, 64'h2000, 1'b1, 2'b00, 3'd0, 64'h0},
    '{2'b10, FX, 1'b0, 7'h01, 5'd2, 5'd3,  5'd1, 64'h1000, 64'h2000, 1'b1, 2'b00, 3'd0, 64'h0},
    '{2'b00, FX, 1'b1, 7'h02, 5'd2, 5'd3,  5'd1, 64'hFFFF_FFFF_FFFF_FFFC, 64'h2000, 1'b1, 2'b00, 3'd1, 64'h4}
  };

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    insn_i         = {v.opc, v.fix, v.ld, v.imm, v.rt2, v.rn, v.rt};
    base_rdata_i   = v.base;
    sp_i           = v.sp;
    align_chk_en_i = v.en;
    ovl_policy_i   = v.pol;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic m, pair, spb, exp_fault;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 valid", {63'd0, valid_o}, 64'd0);
    chk("R10 addr", addr_o, 64'd0);
    chk("R10 kind", {61'd0, kind_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R10 after release", {62'd0, match_o, tag_chk_o}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      valid_i = 1'b1;
      // R5: combinational read index
      #1 chk("R5 rf_raddr", {59'd0, rf_raddr_o}, {59'd0, VEC[i].rn});
      @(negedge clk);
      m    = (VEC[i].fix == FX) && VEC[i].ld;
      pair = (VEC[i].kind == 3'd1) || (VEC[i].kind == 3'd2);
      spb  = pair && (VEC[i].rn == 5'd31);
      exp_fault = spb && VEC[i].en && (VEC[i].sp[3:0] != 4'd0);
      chk($sformatf("R9 valid v%0d", i), {63'd0, valid_o}, 64'd1);
      chk($sformatf("R1 match v%0d", i), {63'd0, match_o}, {63'd0, m});
      chk($sformatf("R2 R7 kind v%0d", i), {61'd0, kind_o}, {61'd0, VEC[i].kind});
      chk($sformatf("R3 fields v%0d", i), {49'd0, rt_o, rn_o, rt2_o},
          m ? {49'd0, VEC[i].rt, VEC[i].rn, VEC[i].rt2} : 64'd0);
      chk($sformatf("R4 R8 addr v%0d", i), addr_o, VEC[i].addr);
      chk($sformatf("R5 sp/tag v%0d", i), {62'd0, sp_base_o, tag_chk_o},
          {62'd0, spb, pair && !spb});
      chk($sformatf("R6 fault v%0d", i), {63'd0, sp_align_fault_o}, {63'd0, exp_fault});
      chk($sformatf("R7 rt_unknown v%0d", i), {63'd0, rt_unknown_o},
          {63'd0, pair && (VEC[i].rt == VEC[i].rt2)});
    end

    // R9: hold while valid low
    valid_i = 1'b0;
    apply(VEC[1]);
    @(negedge clk);
    chk("R9 valid drop", {63'd0, valid_o}, 64'd0);
    chk("R9 addr hold", addr_o, 64'h4);
    chk("R9 kind hold", {61'd0, kind_o}, 64'd1);

    // R10: asynchronous reset mid-run
    valid_i = 1'b1;
    @(negedge clk);
    chk("R4 pre-reset addr", addr_o, 64'h1008);
    #1 rst_ni = 1'b0;
    #1 chk("R10 async addr", addr_o, 64'd0);
    chk("R10 async kind", {61'd0, kind_o}, 64'd0);
    chk("R10 async valid", {63'd0, valid_o}, 64'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule